// File: doc/BRIEF.md
# Event-Driven Processor Wake Controller

This block keeps a host processor parked in reset while there is nothing to do. Two asynchronous event lines wake it: one fires when a key is pressed, the other when the speech unit finishes a sound. Each line is synchronized and edge-detected, and each rising edge sets its own sticky flag. The first flag that is set while the wake timer is idle starts the timer. The timer counts a fixed number of clock-enable ticks, and when it expires the processor reset output is released.

Once running, the processor reads both flags as bits of a status byte. It acknowledges each flag by reading a dedicated address. The address decode uses address bits 14 down to 11 only, so the two strobes mirror across the rest of the address space. Each strobe returns all ones on the read data bus. If an acknowledge leaves both flags clear, the block asserts processor reset again on the next edge and cancels any pending wake delay. The processor has in this way put itself back to sleep.

Top module: `wake_ctl`

## Requirements
- R1: After reset, both flags are clear, `status_o` is 0x00, `cpu_rst` is 1 and no wake delay is pending.
- R2: A rising edge on `key_evt` sets the key flag, seen as `status_o[6]`, on the third clock edge after the input rises (two synchronizer stages plus the flag register).
- R3: A rising edge on `done_evt` sets the phoneme flag, seen as `status_o[7]`, with the same three-edge latency. The other status bits always read 0.
- R4: An event input that is held high counts as one event. A flag that is cleared while its input stays high remains clear.
- R5: When a flag is set while the timer is idle, `cpu_rst` falls on exactly the `DELAY_TICKS`-th enabled clock edge after the flag-set edge. With `tick_en` held at 1 and `DELAY_TICKS`=32, this is edge 35 after the input rises.
- R6: An event that arrives while the wake delay is running does not restart the delay.
- R7: The delay counter advances only on edges where `tick_en` is 1.
- R8: A read with `rd_en`=1 and `rd_addr[14:11]`=4'b1100 clears the phoneme flag. A read with `rd_addr[14:11]`=4'b1101 clears the key flag. `rd_addr[15]` and `rd_addr[10:0]` are ignored, and a read to any other region changes no flag.
- R9: An acknowledge that leaves one flag still set keeps `cpu_rst` at 0. An acknowledge that leaves both flags clear sets `cpu_rst` to 1 on that edge and cancels a pending delay.
- R10: `rd_data` is 0xFF while a decoded acknowledge read is presented, and 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Clock enable for the wake delay counter |
| key_evt | input | 1 | Asynchronous key-press event |
| done_evt | input | 1 | Asynchronous speech-done event |
| rd_en | input | 1 | Processor read strobe |
| rd_addr | input | ADDR_W | Processor read address |
| rd_data | output | 8 | Read data for acknowledge reads |
| status_o | output | 8 | Flag status byte: bit 7 phoneme, bit 6 key |
| cpu_rst | output | 1 | Processor reset, active high |

## Verification
The hardest case to reach is an acknowledge that arrives while the wake delay is still counting. A real processor cannot issue one, because it is held in reset during that time. The bench drives the read port directly in the middle of the delay and clears the only set flag. It then waits well past the expiry point and checks that the reset never drops. Restart protection is covered in a similar way: a second event is injected partway through the delay, and the bench checks that the release still falls on the edge fixed by the first event.

// File: rtl/wake_ctl.sv
module wake_ctl #(
  parameter int DELAY_TICKS = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              key_evt,
  input  logic              done_evt,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [7:0]        status_o,
  output logic              cpu_rst
);
  localparam int CNT_W = $clog2(DELAY_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);
  localparam logic [3:0] REGION_PHON = 4'b1100;
  localparam logic [3:0] REGION_KEY  = 4'b1101;

  logic [SYNC_STAGES-1:0] key_sync, done_sync;
  logic key_prev, done_prev;
  logic key_f, phon_f;
  logic running;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_sync  <= '0;
      done_sync <= '0;
      key_prev  <= 1'b0;
      done_prev <= 1'b0;
    end else begin
      key_sync  <= {key_sync[SYNC_STAGES-2:0], key_evt};
      done_sync <= {done_sync[SYNC_STAGES-2:0], done_evt};
      key_prev  <= key_sync[SYNC_STAGES-1];
      done_prev <= done_sync[SYNC_STAGES-1];
    end
  end

  wire rise_key  = key_sync[SYNC_STAGES-1] & ~key_prev;
  wire rise_done = done_sync[SYNC_STAGES-1] & ~done_prev;
  wire any_rise  = rise_key | rise_done;

  wire [3:0] region = rd_addr[ADDR_W-2 -: 4];
  wire hit_phon = rd_en && (region == REGION_PHON);
  wire hit_key  = rd_en && (region == REGION_KEY);
  wire any_hit  = hit_phon | hit_key;

  wire [1:0] flags_nx = ({phon_f, key_f} & ~{hit_phon, hit_key}) | {rise_done, rise_key};
  wire sleep_now = any_hit && (flags_nx == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phon_f  <= 1'b0;
      key_f   <= 1'b0;
      running <= 1'b0;
      cnt     <= '0;
      cpu_rst <= 1'b1;
    end else begin
      {phon_f, key_f} <= flags_nx;
      if (sleep_now) begin
        cpu_rst <= 1'b1;
        running <= 1'b0;
        cnt     <= '0;
      end else if (any_rise && !running) begin
        running <= 1'b1;
        cnt     <= '0;
      end else if (running && tick_en) begin
        if (cnt == LAST) begin
          running <= 1'b0;
          cnt     <= '0;
          cpu_rst <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign status_o = {phon_f, key_f, 6'b0};
  assign rd_data  = any_hit ? 8'hFF : 8'h00;

  // An awake processor always has at least one pending flag
  p_awake_has_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rst |-> (phon_f | key_f));

  // Reset is released only by an expiring, enabled delay
  p_release_on_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst) |-> ($past(running) && $past(tick_en) && $past(cnt) == LAST));

  // A running delay never jumps back; it holds or advances with tick_en
  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> (cnt == $past(cnt) + CNT_W'($past(tick_en))));

  // Flags fall only through their own acknowledge strobe
  p_key_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(key_f) |-> $past(hit_key));
  p_phon_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phon_f) |-> $past(hit_phon));

  // Acknowledge that empties both flags puts the processor to sleep
  p_sleep_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |=> (phon_f | key_f | cpu_rst));

  // Acknowledge reads return all ones
  p_ack_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> rd_data == 8'hFF);
endmodule

// File: tb/wake_ctl_test.sv
module wake_ctl_test;
  localparam int DLY = 32;
  logic clk = 0, rst_n = 0, tick_en = 1, key_evt = 0, done_evt = 0, rd_en = 0;
  logic [15:0] rd_addr = 16'h0000;
  logic [7:0] rd_data, status_o;
  logic cpu_rst;
  logic half_rate = 0;
  int total = 0, bad = 0;
  bit finished = 0;

  wake_ctl #(.DELAY_TICKS(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .key_evt(key_evt),
    .done_evt(done_evt), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .status_o(status_o), .cpu_rst(cpu_rst));

  always #2 clk = ~clk;

  always @(posedge clk) tick_en <= half_rate ? ~tick_en : 1'b1;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset;
    rst_n = 0; key_evt = 0; done_evt = 0; rd_en = 0; half_rate = 0;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  task automatic ack(input logic [15:0] a, input string req, input int exp_data);
    rd_en = 1; rd_addr = a;
    #0.5;
    chk(req, "rd_data", rd_data, exp_data);
    step(1);
    rd_en = 0; rd_addr = 16'h0000;
  endtask

  task automatic t_reset;
    do_reset();
    chk("R1", "status", status_o, 8'h00);
    chk("R1", "cpu_rst", cpu_rst, 1);
    step(DLY + 5);
    chk("R1", "cpu_rst idle", cpu_rst, 1);
  endtask

  task automatic t_key_wake;
    do_reset();
    key_evt = 1;
    step(2);
    chk("R2", "key flag early", status_o, 8'h00);
    step(1);
    chk("R2", "key flag set", status_o, 8'h40);
    step(DLY - 1);
    chk("R5", "still in reset", cpu_rst, 1);
    step(1);
    chk("R5", "released", cpu_rst, 0);
    key_evt = 0;
  endtask

  task automatic t_done_wake;
    do_reset();
    done_evt = 1;
    step(3);
    chk("R3", "phon flag set", status_o, 8'h80);
    done_evt = 0;
    step(DLY);
    chk("R5", "released by done", cpu_rst, 0);
  endtask

  task automatic t_no_restart;
    do_reset();
    key_evt = 1;
    step(10);
    done_evt = 1;
    step(DLY - 8);
    chk("R6", "status both", status_o, 8'hC0);
    chk("R6", "still in reset", cpu_rst, 1);
    step(1);
    chk("R6", "release on original edge", cpu_rst, 0);
    key_evt = 0; done_evt = 0;
  endtask

  task automatic t_held_level;
    do_reset();
    key_evt = 1;
    step(DLY + 3);
    chk("R4", "awake", cpu_rst, 0);
    ack(16'h6800, "R10", 8'hFF);
    chk("R4", "flag cleared", status_o, 8'h00);
    step(20);
    chk("R4", "held level no retrigger", status_o, 8'h00);
    chk("R4", "asleep", cpu_rst, 1);
    key_evt = 0;
  endtask

  task automatic t_decode;
    do_reset();
    key_evt = 1; done_evt = 1;
    step(DLY + 3);
    key_evt = 0; done_evt = 0;
    chk("R8", "both set", status_o, 8'hC0);
    ack(16'h7000, "R10", 8'h00);
    chk("R8", "other region no effect", status_o, 8'hC0);
    ack(16'h0800, "R10", 8'h00);
    chk("R8", "low region no effect", status_o, 8'hC0);
    ack(16'hE7FF, "R10", 8'hFF);
    chk("R8", "mirror clears phoneme", status_o, 8'h40);
    chk("R9", "one flag left stays awake", cpu_rst, 0);
    ack(16'hE800, "R10", 8'hFF);
    chk("R8", "mirror clears key", status_o, 8'h00);
    chk("R9", "last ack sleeps", cpu_rst, 1);
  endtask

  task automatic t_cancel;
    do_reset();
    done_evt = 1;
    step(10);
    done_evt = 0;
    ack(16'h6000, "R10", 8'hFF);
    chk("R9", "flag cleared mid delay", status_o, 8'h00);
    step(DLY + 10);
    chk("R9", "pending delay cancelled", cpu_rst, 1);
  endtask

  task automatic t_half_rate;
    int released_at;
    do_reset();
    half_rate = 1;
    key_evt = 1;
    step(3);
    released_at = -1;
    for (int i = 1; i <= 2 * DLY + 6; i++) begin
      step(1);
      if (released_at < 0 && cpu_rst == 0) released_at = i;
    end
    chk("R7", "not released early", (released_at > DLY + 2) ? 1 : 0, 1);
    chk("R7", "released by double time", (released_at > 0 && released_at <= 2 * DLY + 2) ? 1 : 0, 1);
    key_evt = 0; half_rate = 0;
  endtask

  initial begin
    t_reset();
    t_key_wake();
    t_done_wake();
    t_no_restart();
    t_held_level();
    t_decode();
    t_cancel();
    t_half_rate();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule